// File: doc/BRIEF.md
# External Interrupt Request Logic

This block turns two external interrupt pins into requests for a processor core. Each source has a mode bit that selects level sensing or falling-edge sensing, and the mode can be changed at any time. The input a source sees is its external pin ANDed with the matching port output latch bit. That combined level passes through a two-flop synchronizer. The block then sets a request flag for the source in a control register that software can read and write.

A set flag becomes a pending interrupt only when its own enable bit and the global enable bit are both 1. The pending source is presented on a valid/ready handshake together with its fixed vector address. When both sources are pending, source 0 is presented. A transfer happens when `irq_valid_o` and `irq_ready_i` are both high. A transfer clears the flag of an edge-mode source. Once `irq_valid_o` is asserted, it stays high and keeps its source until a transfer happens, unless software clears the flag, changes the enables, or source 0 becomes pending while source 1 is shown. A level-mode flag ignores the handshake and simply follows its input.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the control register and the enable register both read 0x00 and `irq_valid_o` is 0, provided the pins and latch bits are high.
- R2: The level a source sees is `pin_i[n] & latch_i[n]`. A latch bit of 0 holds that input low even when the pin is high.
- R3: A drop of the input shows up in the request flag on the third rising clock edge after it, never earlier. Two of these edges are the synchronizer and one is the flag register.
- R4: In level mode (mode bit 0), the flag is 1 for every cycle the synchronized input is low and 0 once it is high. A software write or a handshake cannot clear it while the input stays low.
- R5: In edge mode (mode bit 1), the flag is set only by a high-to-low change between successive synchronized samples. Holding the input low does not set it again after it has been cleared.
- R6: In edge mode, a completed handshake clears the flag of the presented source only. A hardware set in the same cycle wins over that clear.
- R7: Control register (`reg_sel_i`=0): bit 0 is mode 0, bit 1 is mode 1, bit 4 is flag 0 and bit 5 is flag 1. The other bits read 0. A write updates both mode bits, and it updates the flags of edge-mode sources.
- R8: Enable register (`reg_sel_i`=1): bit 0 enables source 0, bit 1 enables source 1 and bit 7 is the global enable. A flag is pending only when its own enable bit and the global enable bit are both 1.
- R9: Source 0 presents vector 0x0003 with `irq_src_o`=0. Source 1 presents vector 0x0013 with `irq_src_o`=1. When both are pending, source 0 is presented, and the vector is valid in the same cycle as `irq_valid_o`.
- R10: While `irq_valid_o` is 1 and `irq_ready_i` is 0, with no register write, the edge-mode request stays pending with the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | External interrupt pins, one per source |
| latch_i | input | 2 | Port output latch bits for those pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_valid_o | output | 1 | A qualified request is presented |
| irq_ready_i | input | 1 | The core accepts the presented request |
| irq_vec_o | output | 16 | Vector address of the presented source |
| irq_src_o | output | 1 | Index of the presented source |

## Verification
The assertions assume that `rst_n` is low at time zero.

They also assume that the pins and latch bits may change at any time but count only after synchronization, so the properties are stated on the synchronized level and never on the raw pins. For source 0 to be shown with priority, each property relies on the enables being stable in that cycle.

The stimulus changes pins, latches, register writes and ready only one time unit after a rising edge. It performs register writes only between handshake scenarios and never while it is holding a request un-accepted.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned VEC_W  = 16;

  // control register fields
  localparam int unsigned CTL_MODE_LSB = 0;
  localparam int unsigned CTL_FLAG_LSB = 4;
  // enable register fields
  localparam int unsigned ENA_SRC_LSB  = 0;
  localparam int unsigned ENA_GLOBAL   = 7;

  localparam logic [VEC_W-1:0] VEC_SRC0 = 16'h0003;
  localparam logic [VEC_W-1:0] VEC_SRC1 = 16'h0013;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_ENA = 1'b1} reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[b] <= '1;
      else        chain_q[b] <= {chain_q[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,     // synchronized input level
  input  logic mode_i,    // 0 level, 1 falling edge
  input  logic wr_i,      // software write to control register
  input  logic wr_flag_i, // flag value written
  input  logic ack_i,     // handshake completed for this source
  output logic flag_o
);
  logic prev_q;
  logic fall;
  logic flag_d;

  assign fall = prev_q & ~lvl_i;

  always_comb begin
    if (!mode_i) begin
      flag_d = ~lvl_i;
    end else begin
      flag_d = flag_o;
      if (wr_i)  flag_d = wr_flag_i;
      if (ack_i) flag_d = 1'b0;
      if (fall)  flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_o <= flag_d;
    end
  end

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !lvl_i) |=> flag_o);
  // R5
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && prev_q && !lvl_i) |=> flag_o);
  // R10
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && flag_o && !ack_i && !wr_i) |=> flag_o);
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend_i,
  output logic [NSRC-1:0]  grant_o,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             src_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    src_o   = 1'b0;
    if (pend_i[0]) begin
      grant_o[0] = 1'b1;
      vec_o      = VEC_SRC0;
    end else if (pend_i[1]) begin
      grant_o[1] = 1'b1;
      vec_o      = VEC_SRC1;
      src_o      = 1'b1;
    end
  end
  assign valid_o = |pend_i;

  // R9
  src0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[0] |-> (vec_o == VEC_SRC0 && !src_o));
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (valid_o == (grant_o != '0)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pin_i,
  input  logic [NSRC-1:0]   latch_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              irq_src_o
);
  logic [NSRC-1:0] mode_q, en_q, lvl, flag, pend, grant;
  logic            gen_q;
  logic            wr_ctl, wr_ena;

  assign wr_ctl = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
  assign wr_ena = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_ENA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      gen_q  <= 1'b0;
    end else begin
      if (wr_ctl) mode_q <= reg_wdata_i[CTL_MODE_LSB +: NSRC];
      if (wr_ena) begin
        en_q  <= reg_wdata_i[ENA_SRC_LSB +: NSRC];
        gen_q <= reg_wdata_i[ENA_GLOBAL];
      end
    end
  end

  ext_irq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i & latch_i), .q_o(lvl)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    ext_irq_detect det_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[s]), .mode_i(mode_q[s]),
      .wr_i(wr_ctl), .wr_flag_i(reg_wdata_i[CTL_FLAG_LSB + s]),
      .ack_i(grant[s] & irq_valid_o & irq_ready_i), .flag_o(flag[s])
    );
  end

  assign pend = flag & en_q & {NSRC{gen_q}};

  ext_irq_arb arb_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .grant_o(grant),
    .valid_o(irq_valid_o), .vec_o(irq_vec_o), .src_o(irq_src_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_e'(reg_sel_i) == SEL_CTRL) begin
      reg_rdata_o[CTL_MODE_LSB +: NSRC] = mode_q;
      reg_rdata_o[CTL_FLAG_LSB +: NSRC] = flag;
    end else begin
      reg_rdata_o[ENA_SRC_LSB +: NSRC] = en_q;
      reg_rdata_o[ENA_GLOBAL]          = gen_q;
    end
  end

  // R8
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !irq_valid_o);
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pin_i = 2'b11;
  logic [1:0]  latch_i = 2'b11;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        irq_valid_o;
  logic        irq_ready_i = 1'b0;
  logic [15:0] irq_vec_o;
  logic        irq_src_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .latch_i(latch_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_valid_o(irq_valid_o),
    .irq_ready_i(irq_ready_i), .irq_vec_o(irq_vec_o), .irq_src_o(irq_src_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    step(1);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [7:0] rd(input logic sel);
    reg_sel_i = sel;
    return reg_rdata_o;
  endfunction

  task automatic t_reset();
    chk("R1 ctrl", rd(0), 8'h00);
    #0 chk("R1 ena", rd(1), 8'h00);
    chk("R1 valid", irq_valid_o, 0);
  endtask

  task automatic t_sync_level();
    pin_i[0] = 1'b0;
    step(2);
    reg_sel_i = 0; #0;
    chk("R3 early", reg_rdata_o[4], 0);
    step(1);
    chk("R3 third edge", reg_rdata_o[4], 1);
    wr(0, 8'h00);
    chk("R4 write no clear", reg_rdata_o[4], 1);
    pin_i[0] = 1'b1;
    step(3);
    chk("R4 follows high", reg_rdata_o[4], 0);
  endtask

  task automatic t_latch();
    latch_i[1] = 1'b0;
    step(3);
    reg_sel_i = 0; #0;
    chk("R2 latch low", reg_rdata_o[5], 1);
    latch_i[1] = 1'b1;
    step(3);
    chk("R2 latch high", reg_rdata_o[5], 0);
  endtask

  task automatic t_edge();
    wr(0, 8'h03);
    pin_i = 2'b00;
    step(3);
    reg_sel_i = 0; #0;
    chk("R5 R7 edge set", reg_rdata_o, 8'h33);
    wr(0, 8'h03);
    step(5);
    chk("R5 no reset while low", reg_rdata_o, 8'h03);
    wr(0, 8'h23);
    chk("R7 write sets edge flag", reg_rdata_o, 8'h23);
    wr(0, 8'h03);
    pin_i = 2'b11;
    step(3);
    pin_i[0] = 1'b0;
    step(3);
    chk("R5 refall", reg_rdata_o, 8'h13);
  endtask

  task automatic t_enable();
    chk("R8 no enables", irq_valid_o, 0);
    wr(1, 8'h01);
    chk("R8 no global", irq_valid_o, 0);
    wr(1, 8'h80);
    chk("R8 only global", irq_valid_o, 0);
    wr(1, 8'h83);
    reg_sel_i = 1; #0;
    chk("R8 readback", reg_rdata_o, 8'h83);
    chk("R8 both", irq_valid_o, 1);
    chk("R9 vec0", irq_vec_o, 16'h0003);
  endtask

  task automatic t_prio();
    pin_i = 2'b11;
    step(3);
    pin_i = 2'b00;
    step(3);
    chk("R9 both vec", irq_vec_o, 16'h0003);
    chk("R9 both src", irq_src_o, 0);
    step(4);
    chk("R10 held valid", irq_valid_o, 1);
    chk("R10 held vec", irq_vec_o, 16'h0003);
    irq_ready_i = 1'b1;
    step(1);
    irq_ready_i = 1'b0;
    reg_sel_i = 0; #0;
    chk("R6 only src0 cleared", reg_rdata_o, 8'h23);
    chk("R9 vec1", irq_vec_o, 16'h0013);
    chk("R9 src1", irq_src_o, 1);
    irq_ready_i = 1'b1;
    step(1);
    irq_ready_i = 1'b0;
    chk("R6 all served", irq_valid_o, 0);
  endtask

  task automatic t_level_ack();
    wr(0, 8'h00);
    step(1);
    irq_ready_i = 1'b1;
    step(2);
    irq_ready_i = 1'b0;
    reg_sel_i = 0; #0;
    chk("R4 ack ignored level", reg_rdata_o, 8'h30);
    chk("R4 still valid", irq_valid_o, 1);
    pin_i = 2'b11;
    step(3);
    chk("R4 released", irq_valid_o, 0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_sync_level();
        t_latch();
        t_edge();
        t_enable();
        t_prio();
        t_level_ack();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule